// File: doc/BRIEF.md
# Redundant Channel Switch-Over Controller

This block decides which of two redundant processing channels, A and B, drives a word of plant outputs. Each channel delivers a health flag and an output word. The controller passes the word of the online channel to the plant port. It changes the online channel only when that channel has lost its health and the other channel is healthy. The changeover is one-directional: when the failed channel recovers later, the controller does not switch back to it.

If both channels are unhealthy at the same moment, the controller keeps the online channel it had and drives a parameterised fail-safe word instead of either channel's output. It also raises an alarm flag while this lasts. During maintenance a manual override can route either channel to the plant, whatever the health flags or the automatic state say. The automatic state machine keeps running during the override, and it takes over again as soon as the override is released.

Each health flag passes through a two-flop synchroniser. A change is then accepted only after it has held for a parameterised number of cycles, so short glitches are ignored. The plant word is registered on the same edge as the online-channel status, so a changeover never shows an intermediate value.

Top module: `chan_switchover`

## Requirements
- R1: While reset is asserted and right after it: channel A is online (`online_is_b`=0), both qualified health flags are unhealthy, `both_failed`=1, `plant_word`=FAIL_SAFE and `manual_active`=0.
- R2: Without override, the online channel changes only when its qualified health is 0 and the other channel's qualified health is 1. A failing standby causes no switch. A recovering channel is never switched back to while the online one stays healthy.
- R3: When both qualified health flags are 0 and no override is active, the online channel is retained, `both_failed`=1 and `plant_word`=FAIL_SAFE.
- R4: When the online channel's qualified health is 1, `plant_word` equals that channel's input word as sampled at the previous clock edge, with exactly one edge of latency.
- R5: With `maint_en`=1, the channel chosen by `maint_sel_b` (1 selects B, 0 selects A) is routed unchanged, even if both channels are unhealthy. `online_is_b` reports the routed channel and `manual_active`=1. These take effect three edges after the pins change: two synchroniser edges and one output edge. Once the override is released, routing follows the automatic state.
- R6: A changeover updates `online_is_b` and `plant_word` on the same clock edge, and `plant_word` then carries the new channel's word.
- R7: Leaving the both-failed condition, if the retained channel recovers, it resumes without a switch. If only the other channel recovers, the controller switches to it.
- R8: A health pin change reaches the outputs exactly 3+STABLE_CYCLES edges after it is sampled. A change that lasts fewer than STABLE_CYCLES cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| health_a_raw | input | 1 | Channel A health flag, asynchronous, 1 = healthy |
| health_b_raw | input | 1 | Channel B health flag, asynchronous, 1 = healthy |
| word_a | input | WORD_W | Channel A output word |
| word_b | input | WORD_W | Channel B output word |
| maint_en | input | 1 | Manual maintenance override enable, asynchronous |
| maint_sel_b | input | 1 | Override choice: 1 = channel B, 0 = channel A |
| plant_word | output | WORD_W | Registered word driven to the plant |
| online_is_b | output | 1 | Registered: 1 when channel B is routed |
| both_failed | output | 1 | Registered alarm: both channels unhealthy |
| manual_active | output | 1 | Registered: override in force |

## Verification
The bench builds the block with WORD_W=8, STABLE_CYCLES=4 and FAIL_SAFE=8'hA5. A non-zero fail-safe word can be told apart from a zero channel word and from the reset value of a register. A filter length of four makes the exact 7-edge health latency measurable. It also lets a 3-cycle pulse sit just one cycle short of acceptance. With these values, every automatic transition, the both-failed retention in each state, recovery toward either channel and an override during a double failure can all be reached within a short run.

// File: rtl/swo_pkg.sv
package swo_pkg;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    typedef struct packed {
        logic b;
        logic a;
    } health_t;

    typedef struct packed {
        logic en;
        logic sel_b;
    } maint_t;

    function automatic chan_e peer(input chan_e c);
        return (c == CH_A) ? CH_B : CH_A;
    endfunction

    function automatic logic chan_ok(input health_t h, input chan_e c);
        return (c == CH_B) ? h.b : h.a;
    endfunction

    function automatic logic all_down(input health_t h);
        return !h.a && !h.b;
    endfunction

endpackage

// File: rtl/swo_sync.sv
module swo_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/swo_health_filter.sv
module swo_health_filter #(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (din == q) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            q   <= din;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swo_fsm.sv
module swo_fsm
    import swo_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  health_t hq,
    output chan_e   state_q,
    output chan_e   state_d
);
    always_comb begin
        state_d = state_q;
        if (!chan_ok(hq, state_q) && chan_ok(hq, peer(state_q)))
            state_d = peer(state_q);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_A;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/swo_out_stage.sv
module swo_out_stage
    import swo_pkg::*;
#(
    parameter int               WORD_W    = 8,
    parameter logic [WORD_W-1:0] FAIL_SAFE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_e             auto_d,
    input  health_t           hq,
    input  maint_t            mnt,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output logic [WORD_W-1:0] plant_word,
    output logic              online_is_b,
    output logic              both_failed,
    output logic              manual_active
);
    chan_e             route;
    logic              down;
    logic [WORD_W-1:0] word_nxt;

    always_comb begin
        route = mnt.en ? chan_e'(mnt.sel_b) : auto_d;
        down  = all_down(hq);
        if (!mnt.en && down)     word_nxt = FAIL_SAFE;
        else if (route == CH_B)  word_nxt = word_b;
        else                     word_nxt = word_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            plant_word    <= FAIL_SAFE;
            online_is_b   <= 1'b0;
            both_failed   <= 1'b1;
            manual_active <= 1'b0;
        end else begin
            plant_word    <= word_nxt;
            online_is_b   <= (route == CH_B);
            both_failed   <= down;
            manual_active <= mnt.en;
        end
    end
endmodule

// File: rtl/chan_switchover.sv
module chan_switchover
    import swo_pkg::*;
#(
    parameter int                WORD_W        = 8,
    parameter int                STABLE_CYCLES = 4,
    parameter logic [WORD_W-1:0] FAIL_SAFE     = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              health_a_raw,
    input  logic              health_b_raw,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  logic              maint_en,
    input  logic              maint_sel_b,
    output logic [WORD_W-1:0] plant_word,
    output logic              online_is_b,
    output logic              both_failed,
    output logic              manual_active
);
    localparam int SYNC_STAGES = 2;
    localparam int N_CHAN      = 2;

    logic [N_CHAN-1:0] health_raw;
    logic [N_CHAN-1:0] health_sync;
    logic [N_CHAN-1:0] health_qual;
    logic [1:0]        maint_sync;
    health_t           hq;
    maint_t            mnt;
    chan_e             state_q;
    chan_e             state_d;

    assign health_raw = {health_b_raw, health_a_raw};

    swo_sync #(.WIDTH(N_CHAN), .STAGES(SYNC_STAGES)) u_hsync (
        .clk (clk), .rst (rst), .din (health_raw), .dout (health_sync)
    );

    swo_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_msync (
        .clk (clk), .rst (rst), .din ({maint_en, maint_sel_b}), .dout (maint_sync)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_filt
        swo_health_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
            .clk (clk), .rst (rst), .din (health_sync[c]), .q (health_qual[c])
        );
    end

    assign hq  = health_t'(health_qual);
    assign mnt = maint_t'(maint_sync);

    swo_fsm u_fsm (
        .clk (clk), .rst (rst), .hq (hq), .state_q (state_q), .state_d (state_d)
    );

    swo_out_stage #(.WORD_W(WORD_W), .FAIL_SAFE(FAIL_SAFE)) u_out (
        .clk           (clk),
        .rst           (rst),
        .auto_d        (state_d),
        .hq            (hq),
        .mnt           (mnt),
        .word_a        (word_a),
        .word_b        (word_b),
        .plant_word    (plant_word),
        .online_is_b   (online_is_b),
        .both_failed   (both_failed),
        .manual_active (manual_active)
    );
endmodule

// File: rtl/chan_switchover_chk.sv
module chan_switchover_chk
    import swo_pkg::*;
#(
    parameter int                WORD_W    = 8,
    parameter logic [WORD_W-1:0] FAIL_SAFE = '0
) (
    input logic              clk,
    input logic              rst,
    input health_t           hq,
    input chan_e             auto_q,
    input logic [WORD_W-1:0] word_a,
    input logic [WORD_W-1:0] word_b,
    input logic [WORD_W-1:0] plant_word,
    input logic              online_is_b,
    input logic              both_failed,
    input logic              manual_active
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!online_is_b && both_failed && !manual_active && plant_word == FAIL_SAFE));

    p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
        (auto_q == CH_A && !(!hq.a && hq.b)) |=> auto_q == CH_A);

    p_hold_b_r2: assert property (@(posedge clk) disable iff (rst)
        (auto_q == CH_B && !(!hq.b && hq.a)) |=> auto_q == CH_B);

    p_failsafe_r3: assert property (@(posedge clk) disable iff (rst)
        (both_failed && !manual_active) |-> plant_word == FAIL_SAFE);

    p_route_r4: assert property (@(posedge clk) disable iff (rst)
        (!both_failed && !manual_active && !online_is_b) |-> plant_word == $past(word_a));

    p_manual_b_r5: assert property (@(posedge clk) disable iff (rst)
        (manual_active && online_is_b) |-> plant_word == $past(word_b));

    p_bumpless_r6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(online_is_b) && !both_failed) |->
            plant_word == (online_is_b ? $past(word_b) : $past(word_a)));
endmodule

bind chan_switchover chan_switchover_chk #(.WORD_W(WORD_W), .FAIL_SAFE(FAIL_SAFE)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .hq            (hq),
    .auto_q        (state_q),
    .word_a        (word_a),
    .word_b        (word_b),
    .plant_word    (plant_word),
    .online_is_b   (online_is_b),
    .both_failed   (both_failed),
    .manual_active (manual_active)
);

// File: tb/chan_switchover_tb_top.sv
module chan_switchover_tb_top;
    localparam int         W  = 8;
    localparam int         ST = 4;
    localparam logic [W-1:0] FS = 8'hA5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ha = 1'b0, hb = 1'b0, men = 1'b0, msb = 1'b0;
    logic [W-1:0] wa = 8'h11, wb = 8'h22;
    logic [W-1:0] plant;
    logic         onb, bf, man;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [W-1:0] word;
        logic         onb;
        logic         bf;
        logic         man;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    chan_switchover #(.WORD_W(W), .STABLE_CYCLES(ST), .FAIL_SAFE(FS)) dut_i (
        .clk (clk), .rst (rst),
        .health_a_raw (ha), .health_b_raw (hb),
        .word_a (wa), .word_b (wb),
        .maint_en (men), .maint_sel_b (msb),
        .plant_word (plant), .online_is_b (onb),
        .both_failed (bf), .manual_active (man)
    );

    task automatic expect_after(input int n, input logic [W-1:0] w, input logic o,
                                input logic b, input logic m, input string tag);
        exp_t e;
        repeat (n) @(posedge clk);
        #1;
        e.word = w; e.onb = o; e.bf = b; e.man = m; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (plant !== e.word || onb !== e.onb || bf !== e.bf || man !== e.man) begin
                bad++;
                $display("FAIL %s: got word=%h onb=%b bf=%b man=%b exp word=%h onb=%b bf=%b man=%b",
                         e.tag, plant, onb, bf, man, e.word, e.onb, e.bf, e.man);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        expect_after(3, FS, 0, 1, 0, "R1 reset held");
        rst = 1'b0;
        expect_after(2, FS, 0, 1, 0, "R1 after reset");
        ha = 1; hb = 1;
        expect_after(12, 8'h11, 0, 0, 0, "R4 A online routes word_a");
        wa = 8'h33;
        expect_after(1, 8'h33, 0, 0, 0, "R4 one edge latency");
        hb = 0;
        expect_after(12, 8'h33, 0, 0, 0, "R2 standby loss no switch");
        ha = 0;
        expect_after(12, FS, 0, 1, 0, "R3 both failed keeps A");
        ha = 1;
        expect_after(12, 8'h33, 0, 0, 0, "R7 retained A resumes");
        hb = 1;
        expect_after(12, 8'h33, 0, 0, 0, "R2 both healthy stays A");
        ha = 0;
        expect_after(6, 8'h33, 0, 0, 0, "R8 not before 3+STABLE edges");
        expect_after(1, 8'h22, 1, 0, 0, "R6 R2 switch to B at edge 7");
        wb = 8'h44;
        expect_after(1, 8'h44, 1, 0, 0, "R4 B word routed");
        ha = 1;
        expect_after(12, 8'h44, 1, 0, 0, "R2 no switch back to A");
        hb = 0;
        repeat (3) @(posedge clk);
        #1 hb = 1;
        expect_after(12, 8'h44, 1, 0, 0, "R8 short pulse ignored");
        ha = 0;
        expect_after(12, 8'h44, 1, 0, 0, "R2 B healthy stays B");
        hb = 0;
        expect_after(12, FS, 1, 1, 0, "R3 both failed keeps B");
        ha = 1;
        expect_after(12, 8'h33, 0, 0, 0, "R7 switch to recovered A");
        men = 1; msb = 1;
        expect_after(2, 8'h33, 0, 0, 0, "R5 override not before 3 edges");
        expect_after(1, 8'h44, 1, 0, 1, "R5 override forces B");
        ha = 0;
        expect_after(12, 8'h44, 1, 1, 1, "R5 override beats fail-safe");
        ha = 1; msb = 0;
        expect_after(12, 8'h33, 0, 0, 1, "R5 override forces A");
        men = 0;
        expect_after(12, 8'h33, 0, 0, 0, "R5 release follows automatic A");
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule